// File: doc/BRIEF.md
# Saturating Doubling Widening Multiply Unit

This block is the lane datapath for signed, saturating, doubling, widening multiplication. It takes narrow signed elements from two 128-bit source vectors and forms their full product. It doubles that product with a saturating self-add at twice the element width. Depending on the operation code it then either returns the doubled value or adds it, with saturation, into a double-width lane taken from an accumulator vector. In subtract mode it adds the negated value instead. Halfword sources (16 bits) give word results, and word sources (32 bits) give doubleword results.

Lanes come from the lower or upper half of each source, as chosen by a half-select bit. In indexed mode, a single element of the second source, picked by three index bits, is broadcast to every lane. In scalar mode only the lowest lane is computed, and every other destination bit is zero. Results are registered one cycle after a start strobe and come with a valid pulse. A sticky flag records any clipping and holds until it is cleared.

Top module: `sqdl_unit`

## Requirements
- R1: `esz` encodes the source element size: 1 = 16-bit (32-bit result), 2 = 32-bit (64-bit result). Codes 0 and 3 are illegal, and so is `op` = 3. An illegal start raises `illegal` together with `res_valid` and leaves `res_out` and `sat_flag` unchanged.
- R2: Each lane forms the exact signed product of its two elements and doubles it with saturation at the result width. The most negative value times itself gives the largest positive value (0x7FFFFFFF for 16-bit sources).
- R3: `op` = 0 returns the doubled product. `op` = 1 adds it to the matching result-width lane of `acc_in`, with saturation. `op` = 2 negates it and then adds it the same way.
- R4: The accumulate step clips to the largest positive or the most negative result-width value when the exact sum leaves that range.
- R5: In vector, non-indexed mode, result lane i uses source element i + L·`q_half` of both sources. L is 4 for 16-bit and 2 for 32-bit sources. Element e of a source sits at bits [e·W +: W], and result lane i at [i·2W +: 2W].
- R6: In indexed mode, the second operand of every lane is element {`idx_h`,`idx_l`,`idx_m`} of `src_b` for 16-bit sources, and element {`idx_h`,`idx_l`} for 32-bit sources. With 32-bit sources `idx_m` has no effect. The first operand is still selected as in R5.
- R7: In scalar mode only lane 0 is computed, from element 0 of `src_a` and element 0 of `src_b` (or the indexed element) and the low lane of `acc_in`. All higher bits of `res_out` are zero, and `q_half` has no effect.
- R8: `res_out` and `illegal` are registered: they appear, with `res_valid` high, in the cycle after `start`. `res_valid` is low in any cycle that does not follow a start.
- R9: `sat_flag` is set when any clip happens in an active lane of a legal operation, and it stays set until `clr_sat`. If a clear and a clipping operation arrive in the same cycle, the flag ends up set.
- R10: After reset, `res_out` is zero and `res_valid`, `illegal` and `sat_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue one operation this cycle |
| clr_sat | input | 1 | Clear the sticky saturation flag |
| esz | input | 2 | Source element size code |
| op | input | 2 | 0 multiply, 1 accumulate, 2 subtract |
| q_half | input | 1 | Take source elements from the upper half |
| scalar_mode | input | 1 | Compute lane 0 only and zero the rest |
| idx_mode | input | 1 | Broadcast an indexed element of src_b |
| idx_h | input | 1 | Index bit, most significant |
| idx_l | input | 1 | Index bit, middle |
| idx_m | input | 1 | Index bit, low (16-bit sources only) |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc_in | input | 128 | Accumulator vector |
| res_out | output | 128 | Registered result vector |
| res_valid | output | 1 | Result strobe, one cycle after start |
| illegal | output | 1 | Last started operation was illegal |
| sat_flag | output | 1 | Sticky saturation indication |

## Verification
A sticky-flag clear and a clipping operation can land in the same cycle. The bench provokes this by issuing a most-negative-squared multiply with `clr_sat` high on the same edge, and expects `sat_flag` to read set afterwards. It also checks the two other cases: a clear with a non-clipping operation must leave the flag low, and a clear on its own must lower it. In the same way, the doubling clip and the accumulate clip can both fire within one lane in one cycle. Accumulating a saturated product into a near-limit accumulator must give exactly one clipped result and a set flag.

// File: rtl/sqdl_pkg.sv
package sqdl_pkg;
  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_S = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_MLA = 2'd1,
    OP_MLS = 2'd2,
    OP_RSV = 2'd3
  } dop_e;

  localparam int unsigned HW_N = 16;
  localparam int unsigned SW_N = 32;
endpackage

// File: rtl/sqdl_rst_sync.sv
module sqdl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/sqdl_satadd.sv
// Signed add of two W-bit values, clamped to the W-bit range.
module sqdl_satadd #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         clip
);
  logic [W:0] full;

  always_comb begin
    full = {x[W-1], x} + {y[W-1], y};
    clip = full[W] ^ full[W-1];
    if (clip) begin
      s = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      s = full[W-1:0];
    end
  end
endmodule

// File: rtl/sqdl_lane.sv
// One widening lane: product, saturating doubling, optional saturating accumulate.
module sqdl_lane
  import sqdl_pkg::*;
#(
  parameter int unsigned NW = 16
) (
  input  logic [NW-1:0]   a,
  input  logic [NW-1:0]   b,
  input  logic [2*NW-1:0] acc,
  input  logic [1:0]      op,
  output logic [2*NW-1:0] res,
  output logic            clip
);
  localparam int unsigned WW = 2 * NW;

  logic signed [WW-1:0] prod;
  logic [WW-1:0]        dbl;
  logic                 dbl_clip;
  logic [WW-1:0]        addend;
  logic [WW-1:0]        sum;
  logic                 sum_clip;

  assign prod = $signed(a) * $signed(b);

  sqdl_satadd #(.W(WW)) u_dbl (
    .x    (prod),
    .y    (prod),
    .s    (dbl),
    .clip (dbl_clip)
  );

  // The doubled product never reaches the most negative value, so a plain
  // two's complement negation cannot overflow here.
  assign addend = (op == OP_MLS) ? (~dbl + 1'b1) : dbl;

  sqdl_satadd #(.W(WW)) u_acc (
    .x    (acc),
    .y    (addend),
    .s    (sum),
    .clip (sum_clip)
  );

  always_comb begin
    if (op == OP_MUL) begin
      res  = dbl;
      clip = dbl_clip;
    end else begin
      res  = sum;
      clip = dbl_clip | sum_clip;
    end
  end
endmodule

// File: rtl/sqdl_opsel.sv
// Picks the narrow operands of every lane for both element sizes.
module sqdl_opsel
  import sqdl_pkg::*;
#(
  parameter int unsigned DW = 128
) (
  input  logic [DW-1:0]                src_a,
  input  logic [DW-1:0]                src_b,
  input  logic                         q_half,
  input  logic                         scalar_mode,
  input  logic                         idx_mode,
  input  logic                         idx_h,
  input  logic                         idx_l,
  input  logic                         idx_m,
  output logic [(DW/(2*HW_N))*HW_N-1:0] ha,
  output logic [(DW/(2*HW_N))*HW_N-1:0] hb,
  output logic [(DW/(2*SW_N))*SW_N-1:0] sa,
  output logic [(DW/(2*SW_N))*SW_N-1:0] sb
);
  localparam int unsigned LH  = DW / (2 * HW_N);
  localparam int unsigned LS  = DW / (2 * SW_N);
  localparam int unsigned NEH = DW / HW_N;
  localparam int unsigned NES = DW / SW_N;

  int unsigned idx_hw;
  int unsigned idx_sw;

  always_comb begin
    idx_hw = {29'd0, idx_h, idx_l, idx_m} % NEH;
    idx_sw = {30'd0, idx_h, idx_l} % NES;
  end

  for (genvar i = 0; i < LH; i++) begin : g_h
    int unsigned ea;
    int unsigned eb;
    always_comb begin
      ea = scalar_mode ? 0 : (i + (q_half ? LH : 0));
      eb = idx_mode ? idx_hw : ea;
      ha[i*HW_N +: HW_N] = src_a[ea*HW_N +: HW_N];
      hb[i*HW_N +: HW_N] = src_b[eb*HW_N +: HW_N];
    end
  end

  for (genvar i = 0; i < LS; i++) begin : g_s
    int unsigned ea;
    int unsigned eb;
    always_comb begin
      ea = scalar_mode ? 0 : (i + (q_half ? LS : 0));
      eb = idx_mode ? idx_sw : ea;
      sa[i*SW_N +: SW_N] = src_a[ea*SW_N +: SW_N];
      sb[i*SW_N +: SW_N] = src_b[eb*SW_N +: SW_N];
    end
  end
endmodule

// File: rtl/sqdl_unit.sv
module sqdl_unit
  import sqdl_pkg::*;
#(
  parameter int unsigned DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clr_sat,
  input  logic [1:0]    esz,
  input  logic [1:0]    op,
  input  logic          q_half,
  input  logic          scalar_mode,
  input  logic          idx_mode,
  input  logic          idx_h,
  input  logic          idx_l,
  input  logic          idx_m,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] acc_in,
  output logic [DW-1:0] res_out,
  output logic          res_valid,
  output logic          illegal,
  output logic          sat_flag
);
  localparam int unsigned LH  = DW / (2 * HW_N);
  localparam int unsigned LS  = DW / (2 * SW_N);
  localparam int unsigned HRW = 2 * HW_N;
  localparam int unsigned SRW = 2 * SW_N;

  logic rst_sync_n;

  sqdl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [LH*HW_N-1:0] ha, hb;
  logic [LS*SW_N-1:0] sa, sb;

  sqdl_opsel #(.DW(DW)) u_sel (
    .src_a       (src_a),
    .src_b       (src_b),
    .q_half      (q_half),
    .scalar_mode (scalar_mode),
    .idx_mode    (idx_mode),
    .idx_h       (idx_h),
    .idx_l       (idx_l),
    .idx_m       (idx_m),
    .ha          (ha),
    .hb          (hb),
    .sa          (sa),
    .sb          (sb)
  );

  logic [LH*HRW-1:0] hres;
  logic [LH-1:0]     hclip;
  logic [LS*SRW-1:0] sres;
  logic [LS-1:0]     sclip;

  for (genvar i = 0; i < LH; i++) begin : g_hl
    sqdl_lane #(.NW(HW_N)) u_lane (
      .a    (ha[i*HW_N +: HW_N]),
      .b    (hb[i*HW_N +: HW_N]),
      .acc  (acc_in[i*HRW +: HRW]),
      .op   (op),
      .res  (hres[i*HRW +: HRW]),
      .clip (hclip[i])
    );
  end

  for (genvar i = 0; i < LS; i++) begin : g_sl
    sqdl_lane #(.NW(SW_N)) u_lane (
      .a    (sa[i*SW_N +: SW_N]),
      .b    (sb[i*SW_N +: SW_N]),
      .acc  (acc_in[i*SRW +: SRW]),
      .op   (op),
      .res  (sres[i*SRW +: SRW]),
      .clip (sclip[i])
    );
  end

  // Next-state logic
  logic          legal;
  logic [DW-1:0] res_nxt;
  logic          clip_any;
  logic          res_en;
  logic          sat_en;
  logic          sat_nxt;

  always_comb begin
    legal    = ((esz == ESZ_H) || (esz == ESZ_S)) && (op != OP_RSV);
    res_nxt  = '0;
    clip_any = 1'b0;
    if (esz == ESZ_H) begin
      for (int i = 0; i < LH; i++) begin
        if (!scalar_mode || (i == 0)) begin
          res_nxt[i*HRW +: HRW] = hres[i*HRW +: HRW];
          clip_any = clip_any | hclip[i];
        end
      end
    end else begin
      for (int i = 0; i < LS; i++) begin
        if (!scalar_mode || (i == 0)) begin
          res_nxt[i*SRW +: SRW] = sres[i*SRW +: SRW];
          clip_any = clip_any | sclip[i];
        end
      end
    end
    res_en  = start & legal;
    sat_en  = clr_sat | (res_en & clip_any);
    sat_nxt = res_en & clip_any;
  end

  // Registers
  logic [DW-1:0] res_q;
  logic          valid_q;
  logic          ill_q;
  logic          sat_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      valid_q <= start;
      ill_q   <= start & ~legal;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sat_q <= 1'b0;
    end else if (sat_en) begin
      sat_q <= sat_nxt;
    end
  end

  assign res_out   = res_q;
  assign res_valid = valid_q;
  assign illegal   = ill_q;
  assign sat_flag  = sat_q;
endmodule

// File: rtl/sqdl_unit_chk.sv
module sqdl_unit_chk #(
  parameter int unsigned DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          clr_sat,
  input logic [1:0]    esz,
  input logic [1:0]    op,
  input logic          scalar_mode,
  input logic [DW-1:0] res_out,
  input logic          res_valid,
  input logic          illegal,
  input logic          sat_flag
);
  logic bad;
  assign bad = (esz == 2'd0) || (esz == 2'd3) || (op == 2'd3);

  // R8
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid);

  // R8
  no_valid_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_valid);

  // R1
  illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bad) |=> (illegal && (res_out == $past(res_out)) && (sat_flag == $past(sat_flag))));

  // R1
  illegal_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> res_valid);

  // R7
  scalar_word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && scalar_mode && (esz == 2'd1) && (op != 2'd3)) |=> (res_out[DW-1:32] == '0));

  // R7
  scalar_dword_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && scalar_mode && (esz == 2'd2) && (op != 2'd3)) |=> (res_out[DW-1:64] == '0));

  // R9
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !clr_sat) |=> sat_flag);

  // R9
  sat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sat && !start) |=> !sat_flag);
endmodule

bind sqdl_unit sqdl_unit_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start       (start),
  .clr_sat     (clr_sat),
  .esz         (esz),
  .op          (op),
  .scalar_mode (scalar_mode),
  .res_out     (res_out),
  .res_valid   (res_valid),
  .illegal     (illegal),
  .sat_flag    (sat_flag)
);

// File: tb/sqdl_unit_bench.sv
module sqdl_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         clr_sat = 1'b0;
  logic [1:0]   esz = 2'd1;
  logic [1:0]   op = 2'd0;
  logic         q_half = 1'b0;
  logic         scalar_mode = 1'b0;
  logic         idx_mode = 1'b0;
  logic         idx_h = 1'b0;
  logic         idx_l = 1'b0;
  logic         idx_m = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [127:0] acc_in = '0;
  logic [127:0] res_out;
  logic         res_valid;
  logic         illegal;
  logic         sat_flag;

  int checks = 0;
  int failures = 0;
  logic [127:0] exp_res = '0;
  logic         exp_sat = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqdl_unit u_sqdl_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .clr_sat(clr_sat),
    .esz(esz), .op(op), .q_half(q_half), .scalar_mode(scalar_mode),
    .idx_mode(idx_mode), .idx_h(idx_h), .idx_l(idx_l), .idx_m(idx_m),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .res_out(res_out), .res_valid(res_valid), .illegal(illegal), .sat_flag(sat_flag)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Returns {clip, result}; result occupies the low 2*nw bits.
  function automatic logic [64:0] lane_m(int nw, logic [31:0] a, logic [31:0] b,
                                         logic [63:0] acc, logic [1:0] opc);
    logic signed [127:0] xa, xb, xc, d, t, mx, mn;
    logic s;
    int wd;
    wd = 2 * nw;
    if (nw == 16) begin
      xa = {{112{a[15]}}, a[15:0]};
      xb = {{112{b[15]}}, b[15:0]};
      xc = {{96{acc[31]}}, acc[31:0]};
    end else begin
      xa = {{96{a[31]}}, a};
      xb = {{96{b[31]}}, b};
      xc = {{64{acc[63]}}, acc};
    end
    mx = (128'sd1 <<< (wd - 1)) - 128'sd1;
    mn = -mx - 128'sd1;
    s = 1'b0;
    d = xa * xb;
    d = d + d;
    if (d > mx) begin d = mx; s = 1'b1; end
    if (d < mn) begin d = mn; s = 1'b1; end
    if (opc != 2'd0) begin
      t = (opc == 2'd2) ? (xc - d) : (xc + d);
      if (t > mx) begin t = mx; s = 1'b1; end
      if (t < mn) begin t = mn; s = 1'b1; end
      d = t;
    end
    return {s, d[63:0]};
  endfunction

  task automatic model(output logic [127:0] r, output logic s);
    int nw, nl, nlanes;
    logic [127:0] av, bv, cv;
    logic [64:0] o;
    r = '0;
    s = 1'b0;
    nw = (esz == 2'd1) ? 16 : 32;
    nl = 128 / (2 * nw);
    nlanes = scalar_mode ? 1 : nl;
    for (int i = 0; i < nlanes; i++) begin
      int ea, eb;
      ea = scalar_mode ? 0 : i + nl * int'(q_half);
      if (idx_mode) eb = (nw == 16) ? int'({idx_h, idx_l, idx_m}) : int'({idx_h, idx_l});
      else eb = ea;
      av = src_a >> (ea * nw);
      bv = src_b >> (eb * nw);
      cv = acc_in >> (i * 2 * nw);
      o = lane_m(nw, av[31:0], bv[31:0], cv[63:0], op);
      if (nw == 16) r[i*32 +: 32] = o[31:0];
      else r[i*64 +: 64] = o[63:0];
      s = s | o[64];
    end
  endtask

  // Issue the operation set up in the input variables and check its outcome.
  task automatic run(string tag);
    logic [127:0] mr;
    logic ms, bad;
    bad = (esz == 2'd0) || (esz == 2'd3) || (op == 2'd3);
    model(mr, ms);
    if (clr_sat) exp_sat = 1'b0;
    if (!bad) begin
      exp_res = mr;
      exp_sat = exp_sat | ms;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    clr_sat = 1'b0;
    chk({tag, " R8 valid"}, {127'd0, res_valid}, 128'd1);
    chk({tag, " R1 illegal"}, {127'd0, illegal}, {127'd0, bad});
    chk({tag, " result"}, res_out, exp_res);
    chk({tag, " R9 sat"}, {127'd0, sat_flag}, {127'd0, exp_sat});
  endtask

  task automatic set_op(logic [1:0] e, logic [1:0] o, logic q, logic sc, logic ix,
                        logic [2:0] hlm);
    esz = e; op = o; q_half = q; scalar_mode = sc; idx_mode = ix;
    {idx_h, idx_l, idx_m} = hlm;
  endtask

  task automatic t_reset();
    chk("R10 res_out", res_out, '0);
    chk("R10 valid", {127'd0, res_valid}, '0);
    chk("R10 illegal", {127'd0, illegal}, '0);
    chk("R10 sat", {127'd0, sat_flag}, '0);
    @(negedge clk);
    chk("R8 idle valid low", {127'd0, res_valid}, '0);
  endtask

  task automatic t_vector();
    src_a = 128'h7fff_8000_0003_fffd_0123_4567_89ab_cdef;
    src_b = 128'h0002_0005_7fff_8001_fedc_ba98_7654_3210;
    acc_in = 128'h0000_0010_ffff_ff00_1234_5678_8765_4321;
    set_op(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0); run("R5 R2 vec16 q0 mul");
    set_op(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0); run("R5 vec16 q1 mul");
    set_op(2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0); run("R5 R3 vec32 q0 acc");
    set_op(2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 3'd0); run("R5 R3 vec32 q1 sub");
    set_op(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0); run("R3 vec16 sub");
  endtask

  task automatic t_minmin();
    src_a = {8{16'h8000}};
    src_b = {8{16'h8000}};
    set_op(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0); run("R2 min*min 16");
    chk("R2 lane0 value", {96'd0, res_out[31:0]}, 128'h7fff_ffff);
    clr_sat = 1'b1; src_a = '0; run("R9 clear with quiet op");
    src_a = {4{32'h8000_0000}};
    src_b = {4{32'h8000_0000}};
    set_op(2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0); run("R2 min*min 32");
    chk("R2 dword value", res_out[63:0], 128'h7fff_ffff_ffff_ffff);
  endtask

  task automatic t_accsat();
    clr_sat = 1'b1;
    @(negedge clk);
    clr_sat = 1'b0;
    exp_sat = 1'b0;
    chk("R9 clear alone", {127'd0, sat_flag}, '0);
    src_a = {8{16'h4000}};
    src_b = {8{16'h4000}};
    acc_in = {32'h7fff_fff0, 32'h8000_0010, 32'h0000_0001, 32'h7000_0000};
    set_op(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0); run("R4 acc clip high");
    chk("R4 top lane max", {96'd0, res_out[127:96]}, 128'h7fff_ffff);
    clr_sat = 1'b1;
    set_op(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0); run("R4 sub clip low");
    chk("R4 lane2 min", {96'd0, res_out[95:64]}, 128'h8000_0000);
    src_a = {8{16'h8000}};
    src_b = {8{16'h8000}};
    acc_in = {4{32'h0000_0005}};
    clr_sat = 1'b1;
    set_op(2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0); run("R9 clear meets clip");
    chk("R9 set wins", {127'd0, sat_flag}, 128'd1);
    clr_sat = 1'b1; src_a = '0; run("R9 reset after");
  endtask

  task automatic t_indexed();
    src_a = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    src_b = 128'h0001_0002_0003_0004_0005_0006_0007_fff9;
    acc_in = 128'h0;
    set_op(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd5); run("R6 idx16 el5");
    set_op(2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 3'd0); run("R6 idx16 el0 q1");
    set_op(2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 3'b100); run("R6 idx32 m0");
    begin
      logic [127:0] first;
      first = res_out;
      idx_m = 1'b1;
      run("R6 idx32 m1");
      chk("R6 m ignored for 32-bit", res_out, first);
    end
  endtask

  task automatic t_scalar();
    src_a = 128'hffff_ffff_ffff_ffff_ffff_ffff_1234_8001;
    src_b = 128'hffff_ffff_ffff_ffff_ffff_ffff_0000_0005;
    acc_in = {4{32'h0100_0000}};
    set_op(2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 3'd0); run("R7 scalar16 acc q1");
    chk("R7 upper zero 16", res_out >> 32, '0);
    set_op(2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 3'd0); run("R7 scalar32 sub");
    chk("R7 upper zero 32", res_out >> 64, '0);
    set_op(2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 3'd1); run("R7 R6 scalar idx");
  endtask

  task automatic t_illegal();
    src_a = {8{16'h8000}};
    src_b = {8{16'h8000}};
    set_op(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0); run("R1 size 8");
    set_op(2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0); run("R1 size 64");
    set_op(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0); run("R1 op 3");
  endtask

  task automatic t_random();
    for (int n = 0; n < 60; n++) begin
      src_a = {$urandom, $urandom, $urandom, $urandom};
      src_b = {$urandom, $urandom, $urandom, $urandom};
      acc_in = {$urandom, $urandom, $urandom, $urandom};
      if (n % 4 == 0) src_a[31:0] = 32'h8000_8000;
      if (n % 4 == 0) src_b = {4{32'h8000_8000}};
      set_op(2'd1 + 2'($urandom % 2), 2'($urandom % 3), 1'($urandom), 1'($urandom),
             1'($urandom), 3'($urandom));
      clr_sat = 1'($urandom % 5 == 0);
      run("R3 R5 random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_vector();
    t_minmin();
    t_accsat();
    t_indexed();
    t_scalar();
    t_illegal();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule